// File: doc/BRIEF.md
# Expansion Bus Address Filter

This block sits between an 8-bit expansion bus and a small register responder. It watches the bus address together with the active-low read and write strobes. Only accesses aimed at the peripheral are passed on. A 256-entry lookup table maps each bus address to a valid flag and a dense 6-bit register index. The mapped registers can therefore sit anywhere in the sparse bus address space and still reach the responder as a compact index space of up to 64 entries.

For a mapped address, the block outputs the register index together with active-high read and write pulses. For an unmapped address, and while no access is in progress, the strobes stay low and the index stays at zero. Setup loads the table through a small write port. An access that drives both strobes at once is an error: it is dropped and a sticky error flag is set. A parameter selects the output path. It is either purely combinational, to leave the most time for the responder inside a short strobe window, or one register stage deep.

Top module: `bus_addr_filter`

## Requirements
- R1: On a mapped address with `bus_rd_n` low and `bus_wr_n` high, `out_rd` is 1 and `out_wr` is 0.
- R2: On a mapped address with `bus_wr_n` low and `bus_rd_n` high, `out_wr` is 1 and `out_rd` is 0.
- R3: On an address whose table entry is invalid, `out_rd` and `out_wr` stay 0 and `out_idx` is 0, whatever the strobes do.
- R4: While an access is forwarded, `out_idx` equals the 6-bit index stored in the table entry of `bus_addr`. Different bus addresses may carry unrelated indices, including 0 and 63.
- R5: After reset, every table entry is invalid, `out_rd`, `out_wr` and `out_idx` are 0, and `err_sticky` is 0.
- R6: A config write (`cfg_we` high) stores `cfg_valid` and `cfg_idx` in entry `cfg_addr` at the rising clock edge. The new mapping applies from that edge on. Writing `cfg_valid`=0 removes the mapping.
- R7: When `bus_rd_n` and `bus_wr_n` are both low, neither strobe is forwarded and `out_idx` is 0, even on a mapped address.
- R8: `err_sticky` becomes 1 at the first rising edge that samples both strobes low. It stays 1 until reset.
- R9: With `REGISTERED`=0, the outputs follow the inputs in the same cycle. With `REGISTERED`=1, they show the same values exactly one clock later.
- R10: While both strobes are high, `out_rd` and `out_wr` are 0 and `out_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Expansion bus address |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 8 | Table entry to write |
| cfg_valid | input | 1 | Valid flag for the entry |
| cfg_idx | input | 6 | Register index for the entry |
| out_idx | output | 6 | Compact register index, 0 when nothing is forwarded |
| out_rd | output | 1 | Forwarded read, active high |
| out_wr | output | 1 | Forwarded write, active high |
| err_sticky | output | 1 | Set by a read/write conflict, cleared only by reset |

## Verification
The hardest case to reach is the one-cycle skew between the two output modes during a strobe transition. In that cycle the combinational copy has already changed and the registered copy still shows the previous access. The bench drives one combinational and one registered instance from the same inputs. It samples both just after each input change and again after the next edge, so the lagging value can be seen on both sides of a strobe assertion and a strobe release. The conflict case comes last, and a second reset follows it. This shows the error flag holding through idle cycles and clearing only on reset.

// File: rtl/bus_filt_pkg.sv
// Shared width and entry type for the expansion bus address filter.
package bus_filt_pkg;
    parameter int unsigned IDX_W = 6;

    // One table entry: mapping flag plus compact register index.
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } map_entry_t;
endpackage

// File: rtl/filt_map_table.sv
// Address-to-index lookup table.
// Holds one valid flag and one index for each bus address. The read port is
// combinational. Writes land at the rising edge. Reset clears only the
// valid flags; the index storage needs no reset because valid gates it.
module filt_map_table
    import bus_filt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  map_entry_t        wr_entry,
    input  logic [ADDR_W-1:0] rd_addr,
    output map_entry_t        rd_entry
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] valid_q;
    logic [IDX_W-1:0] idx_q [DEPTH];

    // Valid flags: cleared on reset, updated by config writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_addr] <= wr_entry.valid;
        end
    end

    // Index storage: written by config writes only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            idx_q[wr_addr] <= wr_entry.idx;
        end
    end

    // Combinational lookup of the current bus address.
    always_comb begin
        rd_entry.valid = valid_q[rd_addr];
        rd_entry.idx   = idx_q[rd_addr];
    end
endmodule

// File: rtl/filt_strobe_gate.sv
// Strobe gating and polarity inversion.
// Turns the active-low bus strobes into active-high forwarded strobes when
// the lookup hits. Exactly one strobe must be active for an access to pass.
// The index is forced to zero unless a strobe is forwarded.
module filt_strobe_gate
    import bus_filt_pkg::*;
(
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             rd_n,
    input  logic             wr_n,
    output logic             fwd_rd,
    output logic             fwd_wr,
    output logic [IDX_W-1:0] fwd_idx,
    output logic             conflict
);
    logic rd_act;
    logic wr_act;

    // Invert the strobes, detect a conflict, and gate on hit.
    always_comb begin
        rd_act   = ~rd_n;
        wr_act   = ~wr_n;
        conflict = rd_act & wr_act;
        fwd_rd   = hit & rd_act & ~wr_act;
        fwd_wr   = hit & wr_act & ~rd_act;
        fwd_idx  = (fwd_rd | fwd_wr) ? hit_idx : '0;
    end
endmodule

// File: rtl/filt_out_stage.sv
// Output stage: a straight wire path, or one register stage, chosen by a
// parameter. The registered variant resets to an idle output.
module filt_out_stage
    import bus_filt_pkg::*;
#(
    parameter bit REGISTERED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_rd,
    input  logic             in_wr,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_rd,
    output logic             out_wr,
    output logic [IDX_W-1:0] out_idx
);
    generate
        if (REGISTERED) begin : g_reg
            // One clock of latency for timing closure.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_rd  <= 1'b0;
                    out_wr  <= 1'b0;
                    out_idx <= '0;
                end else begin
                    out_rd  <= in_rd;
                    out_wr  <= in_wr;
                    out_idx <= in_idx;
                end
            end
        end else begin : g_comb
            // Zero-latency pass-through.
            always_comb begin
                out_rd  = in_rd;
                out_wr  = in_wr;
                out_idx = in_idx;
            end
        end
    endgenerate
endmodule

// File: rtl/bus_addr_filter.sv
// Expansion bus address filter, top level.
// Decodes the bus address through a loadable table and forwards the mapped
// accesses as active-high strobes with a compact register index. It assumes
// the strobes and the address are synchronous to clk, or are slow enough to
// be sampled directly.
module bus_addr_filter
    import bus_filt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter bit          REGISTERED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_valid,
    input  logic [IDX_W-1:0]  cfg_idx,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_rd,
    output logic              out_wr,
    output logic              err_sticky
);
    map_entry_t       wr_entry;
    map_entry_t       lut_entry;
    logic             g_rd;
    logic             g_wr;
    logic [IDX_W-1:0] g_idx;
    logic             g_conflict;

    // Pack the config fields into a table entry.
    always_comb begin
        wr_entry.valid = cfg_valid;
        wr_entry.idx   = cfg_idx;
    end

    filt_map_table #(.ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_entry (wr_entry),
        .rd_addr  (bus_addr),
        .rd_entry (lut_entry)
    );

    filt_strobe_gate u_gate (
        .hit      (lut_entry.valid),
        .hit_idx  (lut_entry.idx),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .fwd_rd   (g_rd),
        .fwd_wr   (g_wr),
        .fwd_idx  (g_idx),
        .conflict (g_conflict)
    );

    filt_out_stage #(.REGISTERED(REGISTERED)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_rd   (g_rd),
        .in_wr   (g_wr),
        .in_idx  (g_idx),
        .out_rd  (out_rd),
        .out_wr  (out_wr),
        .out_idx (out_idx)
    );

    // Sticky conflict flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sticky <= 1'b0;
        end else if (g_conflict) begin
            err_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/filt_chk.sv
// Property checker for bus_addr_filter, attached by bind. It observes only
// the ports of the top module.
module filt_chk
    import bus_filt_pkg::*;
#(
    parameter bit REGISTERED = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd_n,
    input logic             bus_wr_n,
    input logic [IDX_W-1:0] out_idx,
    input logic             out_rd,
    input logic             out_wr,
    input logic             err_sticky
);
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n && !bus_wr_n) |=> err_sticky);

    // R10
    idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rd && !out_wr) |-> (out_idx == '0));

    generate
        if (REGISTERED) begin : g_reg
            // R1
            rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_rd |-> ($past(!bus_rd_n) && $past(bus_wr_n)));
            // R2
            wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_wr |-> ($past(!bus_wr_n) && $past(bus_rd_n)));
        end else begin : g_comb
            // R1
            rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_rd |-> (!bus_rd_n && bus_wr_n));
            // R2
            wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_wr |-> (!bus_wr_n && bus_rd_n));
            // R7
            conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!bus_rd_n && !bus_wr_n) |-> (!out_rd && !out_wr));
        end
    endgenerate
endmodule

bind bus_addr_filter filt_chk #(.REGISTERED(REGISTERED)) u_filt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .out_idx    (out_idx),
    .out_rd     (out_rd),
    .out_wr     (out_wr),
    .err_sticky (err_sticky)
);

// File: tb/test_bus_addr_filter.sv
// Directed bench: one combinational and one registered instance share inputs.
module test_bus_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr;
    logic       bus_rd_n;
    logic       bus_wr_n;
    logic       cfg_we;
    logic [7:0] cfg_addr;
    logic       cfg_valid;
    logic [5:0] cfg_idx;
    logic [5:0] c_idx, q_idx;
    logic       c_rd, c_wr, c_err, q_rd, q_wr, q_err;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    bus_addr_filter #(.REGISTERED(1'b0)) i_bus_addr_filter (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_valid(cfg_valid), .cfg_idx(cfg_idx), .out_idx(c_idx),
        .out_rd(c_rd), .out_wr(c_wr), .err_sticky(c_err));

    bus_addr_filter #(.REGISTERED(1'b1)) i_bus_addr_filter_q (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_valid(cfg_valid), .cfg_idx(cfg_idx), .out_idx(q_idx),
        .out_rd(q_rd), .out_wr(q_wr), .err_sticky(q_err));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output word of one instance: {rd, wr, idx}.
    function automatic int pk(input logic r, input logic w, input logic [5:0] i);
        return {r, w, i};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_addr = '0; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        cfg_we = 1'b0; cfg_addr = '0; cfg_valid = 1'b0; cfg_idx = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input logic [7:0] a, input logic v, input logic [5:0] i);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_valid = v; cfg_idx = i;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Apply bus inputs, check the combinational copy at once and the
    // registered copy after the next edge.
    task automatic access(input logic [7:0] a, input logic rn, input logic wn,
                          input int exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd_n = rn; bus_wr_n = wn;
        #1 chk({req, " comb"}, pk(c_rd, c_wr, c_idx), exp);
        @(posedge clk);
        #1 chk({req, " reg"}, pk(q_rd, q_wr, q_idx), exp);
    endtask

    task automatic t_reset();
        chk("R5 comb out", pk(c_rd, c_wr, c_idx), 0);
        chk("R5 reg out", pk(q_rd, q_wr, q_idx), 0);
        chk("R5 err", {c_err, q_err}, 0);
        access(8'h21, 1'b0, 1'b1, 0, "R5 read before config");
        access(8'hFF, 1'b1, 1'b0, 0, "R5 write before config");
        access(8'h00, 1'b1, 1'b1, 0, "R10 idle");
    endtask

    task automatic t_hits();
        cfg(8'h21, 1'b1, 6'd5);
        cfg(8'hFF, 1'b1, 6'd63);
        cfg(8'h00, 1'b1, 6'd0);
        cfg(8'h80, 1'b1, 6'd42);
        access(8'h21, 1'b0, 1'b1, pk(1, 0, 5), "R1 R4 read 21");
        access(8'h21, 1'b1, 1'b0, pk(0, 1, 5), "R2 R4 write 21");
        access(8'hFF, 1'b0, 1'b1, pk(1, 0, 63), "R1 R4 read FF");
        access(8'h00, 1'b1, 1'b0, pk(0, 1, 0), "R2 R4 write 00");
        access(8'h80, 1'b0, 1'b1, pk(1, 0, 42), "R4 read 80");
        access(8'h80, 1'b1, 1'b1, 0, "R10 idle on mapped");
    endtask

    task automatic t_miss();
        access(8'h22, 1'b0, 1'b1, 0, "R3 read miss");
        access(8'h7F, 1'b1, 1'b0, 0, "R3 write miss");
    endtask

    task automatic t_rewrite();
        cfg(8'h21, 1'b1, 6'd17);
        access(8'h21, 1'b0, 1'b1, pk(1, 0, 17), "R6 remap");
        cfg(8'h21, 1'b0, 6'd17);
        access(8'h21, 1'b0, 1'b1, 0, "R6 unmap");
    endtask

    task automatic t_latency();
        access(8'h80, 1'b1, 1'b1, 0, "R9 idle");
        @(negedge clk);
        bus_rd_n = 1'b0;
        #1 chk("R9 comb same cycle", pk(c_rd, c_wr, c_idx), pk(1, 0, 42));
        chk("R9 reg still idle", pk(q_rd, q_wr, q_idx), 0);
        @(posedge clk);
        #1 chk("R9 reg one later", pk(q_rd, q_wr, q_idx), pk(1, 0, 42));
        @(negedge clk);
        bus_rd_n = 1'b1;
        #1 chk("R9 comb release", pk(c_rd, c_wr, c_idx), 0);
        chk("R9 reg holds", pk(q_rd, q_wr, q_idx), pk(1, 0, 42));
        @(posedge clk);
        #1 chk("R9 reg release", pk(q_rd, q_wr, q_idx), 0);
    endtask

    task automatic t_conflict();
        chk("R8 err clear before", {c_err, q_err}, 0);
        @(negedge clk);
        bus_addr = 8'hFF; bus_rd_n = 1'b0; bus_wr_n = 1'b0;
        #1 chk("R7 comb conflict", pk(c_rd, c_wr, c_idx), 0);
        chk("R8 err not yet", c_err, 0);
        @(posedge clk);
        #1 chk("R7 reg conflict", pk(q_rd, q_wr, q_idx), 0);
        chk("R8 err set", {c_err, q_err}, 3);
        access(8'hFF, 1'b1, 1'b1, 0, "R10 idle after conflict");
        chk("R8 err held", {c_err, q_err}, 3);
        access(8'hFF, 1'b0, 1'b1, pk(1, 0, 63), "R1 after conflict");
        do_reset();
        #1 chk("R8 err cleared by reset", {c_err, q_err}, 0);
        access(8'hFF, 1'b0, 1'b1, 0, "R5 table cleared by reset");
    endtask

    initial begin
        do_reset();
        #1;
        t_reset();
        t_hits();
        t_miss();
        t_rewrite();
        t_latency();
        t_conflict();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule